// File: doc/BRIEF.md
# Set-Associative Instruction Cache Controller

This block sits between an instruction prefetcher and a simple line-refill memory port. It serves one 64-bit fetch at a time, which is enough for four 16-bit or two 32-bit instructions. The array is four ways wide. The set is picked from the virtual fetch address when the fetch is accepted. The physical tag arrives from translation one cycle later and is compared against the stored tags in that same cycle. Each line also records the security world that filled it, so a secure fetch and a non-secure fetch to the same physical line never share an entry.

On a hit the beat is returned in the tag cycle. On a miss the controller asks memory for the 32-byte line, starting with the requested 64-bit beat. It receives four beats in wrapping order and hands the first one straight to the prefetcher. It then installs the line in the way named by that set's round-robin pointer. A separate invalidate-all command walks every set once and clears all valid bits. Total capacity is chosen at elaboration: 16, 32 or 64 KB.

Top module: `icache_vipt`

## Requirements
- R1: After reset no line is valid. `fetchReady` is 1, and `respValid`, `memReqValid` and `invBusy` are 0. The first fetch to any address misses.
- R2: `CACHE_KB` must be 16, 32 or 64. There are `CACHE_KB*1024/128` sets and 32-byte lines. The set index is `fetchVaddr[IDX_W+4:5]` and the beat within the line is `fetchVaddr[4:3]`.
- R3: A fetch is accepted on a clock edge where `fetchValid` and `fetchReady` are both 1. `fetchPtag` must be driven during the following cycle. On a hit, `respValid` is 1 in that cycle and `respData` holds the stored beat.
- R4: A hit needs a valid line in the indexed set whose stored tag equals `fetchPtag`. Virtual address bits above the index take no part in hit detection. The same index with a different physical tag misses.
- R5: A hit also needs the stored security bit to equal the `fetchSecure` value of the request. A refill stores the request's security bit and drives it on `memReqSecure`.
- R6: On a miss, `memReqValid` rises in the cycle after the tag cycle with `memReqAddr = {ptag, index, beat, 3'b000}`. Both are held unchanged until `memReqReady` is 1 on a clock edge.
- R7: A refill takes four `memRespValid` beats for line beats `b, b+1, b+2, b+3` (mod 4), where `b` is the requested beat. The first beat is returned on `respValid`/`respData` in the same cycle it arrives. All four beats are stored and hit on later fetches.
- R8: The refilled way is taken from a per-set round-robin pointer. The pointer starts at way 0 after reset and advances by one on each refill of that set, with no way ever locked. A fifth distinct tag in one set evicts the first.
- R9: A one-cycle `invReq` pulse makes `invBusy` 1 for exactly SETS+1 cycles, starting on the following edge. `fetchReady` is 0 throughout. Afterwards every previously cached line misses.
- R10: Only one fetch is outstanding. `fetchReady` stays 0 from acceptance until the hit response or the last refill beat, and `respValid` is never 1 on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | Prefetcher presents a fetch |
| fetchReady | output | 1 | Controller accepts a fetch this cycle |
| fetchVaddr | input | VA_W | Virtual fetch address (index and beat) |
| fetchSecure | input | 1 | Security world of the fetch |
| fetchPtag | input | PTAG_W | Physical tag, valid the cycle after acceptance |
| respValid | output | 1 | Fetch data returned |
| respData | output | 64 | Returned 64-bit beat |
| invReq | input | 1 | Invalidate-all request pulse |
| invBusy | output | 1 | Invalidate pending or running |
| memReqValid | output | 1 | Line refill request |
| memReqReady | input | 1 | Memory accepts the refill request |
| memReqAddr | output | PA_W | Physical address of the critical beat |
| memReqSecure | output | 1 | Security world of the refill |
| memRespValid | input | 1 | Refill beat present |
| memRespData | input | 64 | Refill beat data |

## Verification
The bench fills one set with five different tags and checks that the first tag is evicted and the later ones still hit. A design with a stuck or per-cache pointer would evict the wrong line. It fetches a middle beat of a line so the wrap order and the forwarded first beat are both checked. A design that refilled from beat 0 or forwarded the wrong beat would return wrong data. It repeats an address with the other security bit and with other virtual upper bits. A design that ignored the world bit would alias the two worlds, and one that compared virtual bits would miss on an alias. It also times the invalidate pass and refetches afterwards. A design that dropped the last set or let fetches through during the pass would show a wrong busy count or a stale hit.

// File: rtl/icache_pkg.sv
package icache_pkg;

  localparam int WAYS       = 4;
  localparam int WAY_W      = 2;
  localparam int LINE_BYTES = 32;
  localparam int OFF_W      = 5;
  localparam int BEATS      = 4;
  localparam int BEAT_SEL_W = 2;
  localparam int DATA_W     = 64;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_MREQ,
    ST_REFILL,
    ST_INVAL
  } ctrlState_t;

  typedef struct packed {
    logic capture;  // latch request, read all ways
    logic lookup;   // tag cycle: latch ptag and victim
    logic beatWe;   // write one refill beat
    logic invStep;  // clear valid bits of one set
    logic fwdSel;   // respData comes from memory port
  } ctrlStrobes_t;

endpackage

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         fetchValid,
  input  logic         invReq,
  input  logic         memReqReady,
  input  logic         memRespValid,
  input  logic         hitAny,
  input  logic         firstBeat,
  input  logic         lastBeat,
  input  logic         invLast,
  output ctrlStrobes_t strobes,
  output logic         fetchReady,
  output logic         respValid,
  output logic         invBusy,
  output logic         memReqValid
);

  ctrlState_t state, stateNext;
  logic invPending;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (invPending) stateNext = ST_INVAL;
                 else if (fetchValid) stateNext = ST_LOOKUP;
      ST_LOOKUP: stateNext = hitAny ? ST_IDLE : ST_MREQ;
      ST_MREQ:   if (memReqReady) stateNext = ST_REFILL;
      ST_REFILL: if (memRespValid && lastBeat) stateNext = ST_IDLE;
      ST_INVAL:  if (invLast) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      invPending <= 1'b0;
    end else begin
      state <= stateNext;
      if (invReq) invPending <= 1'b1;
      else if (state == ST_IDLE && invPending) invPending <= 1'b0;
    end
  end

  always_comb begin
    strobes.capture = (state == ST_IDLE) && !invPending && fetchValid;
    strobes.lookup  = (state == ST_LOOKUP);
    strobes.beatWe  = (state == ST_REFILL) && memRespValid;
    strobes.invStep = (state == ST_INVAL);
    strobes.fwdSel  = (state == ST_REFILL);
  end

  assign fetchReady  = (state == ST_IDLE) && !invPending;
  assign respValid   = ((state == ST_LOOKUP) && hitAny) ||
                       ((state == ST_REFILL) && memRespValid && firstBeat);
  assign invBusy     = invPending || (state == ST_INVAL);
  assign memReqValid = (state == ST_MREQ);

  AST_SINGLE_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && fetchReady |=> !fetchReady); // R10
  AST_RESP_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid); // R10
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid); // R6
  AST_INV_BLOCKS_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    invBusy |-> !fetchReady); // R9

endmodule

// File: rtl/icache_datapath.sv
module icache_datapath
  import icache_pkg::*;
#(
  parameter int SETS   = 128,
  parameter int IDX_W  = 7,
  parameter int PTAG_W = 20,
  parameter int VA_W   = 32,
  parameter int PA_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [VA_W-1:0]    fetchVaddr,
  input  logic               fetchSecure,
  input  logic [PTAG_W-1:0]  fetchPtag,
  input  logic [DATA_W-1:0]  memRespData,
  output logic               hitAny,
  output logic               firstBeat,
  output logic               lastBeat,
  output logic               invLast,
  output logic [DATA_W-1:0]  respData,
  output logic [PA_W-1:0]    memReqAddr,
  output logic               memReqSecure
);

  localparam int DEPTH = SETS * BEATS;

  logic [IDX_W-1:0]      fetchIdx;
  logic [BEAT_SEL_W-1:0] fetchBeat;
  logic                  unusedVaddr;

  logic [IDX_W-1:0]      reqIdx;
  logic [BEAT_SEL_W-1:0] reqBeat;
  logic                  reqSec;
  logic [PTAG_W-1:0]     reqPtag;
  logic [WAY_W-1:0]      victimWay;
  logic [BEAT_SEL_W-1:0] refillCnt;
  logic [BEAT_SEL_W-1:0] wrBeat;
  logic [IDX_W-1:0]      invCnt;
  logic                  commit;

  logic [WAYS-1:0]       validArr [SETS];
  logic [WAY_W-1:0]      rrPtr    [SETS];
  logic [WAYS-1:0]       hitVec;
  logic [WAYS-1:0][DATA_W-1:0] wayBeat;
  logic [DATA_W-1:0]     hitData;

  assign fetchIdx    = fetchVaddr[OFF_W+IDX_W-1:OFF_W];
  assign fetchBeat   = fetchVaddr[OFF_W-1:3];
  assign unusedVaddr = ^{fetchVaddr[VA_W-1:OFF_W+IDX_W], fetchVaddr[2:0]};

  assign wrBeat    = reqBeat + refillCnt;
  assign commit    = strobes.beatWe && lastBeat;
  assign firstBeat = (refillCnt == '0);
  assign lastBeat  = (refillCnt == BEAT_SEL_W'(BEATS - 1));
  assign invLast   = (invCnt == IDX_W'(SETS - 1));

  // request registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqIdx    <= '0;
      reqBeat   <= '0;
      reqSec    <= 1'b0;
      reqPtag   <= '0;
      victimWay <= '0;
      refillCnt <= '0;
      invCnt    <= '0;
    end else begin
      if (strobes.capture) begin
        reqIdx  <= fetchIdx;
        reqBeat <= fetchBeat;
        reqSec  <= fetchSecure;
      end
      if (strobes.lookup) begin
        reqPtag   <= fetchPtag;
        victimWay <= rrPtr[reqIdx];
        refillCnt <= '0;
      end
      if (strobes.beatWe) refillCnt <= refillCnt + 1'b1;
      if (strobes.invStep) invCnt <= invCnt + 1'b1;
    end
  end

  // valid bits and replacement pointers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validArr[s] <= '0;
        rrPtr[s]    <= '0;
      end
    end else begin
      if (strobes.invStep) validArr[invCnt] <= '0;
      if (commit) begin
        validArr[reqIdx][victimWay] <= 1'b1;
        rrPtr[reqIdx]               <= rrPtr[reqIdx] + 1'b1;
      end
    end
  end

  // per-way tag, security and data storage
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [PTAG_W-1:0] tagMem  [SETS];
    logic              secMem  [SETS];
    logic [DATA_W-1:0] dataMem [DEPTH];
    logic [DATA_W-1:0] rdBeat;
    logic              wayHit;

    always_ff @(posedge clk) begin
      if (strobes.capture) rdBeat <= dataMem[{fetchIdx, fetchBeat}];
      if (strobes.beatWe && victimWay == WAY_W'(w))
        dataMem[{reqIdx, wrBeat}] <= memRespData;
      if (commit && victimWay == WAY_W'(w)) begin
        tagMem[reqIdx] <= reqPtag;
        secMem[reqIdx] <= reqSec;
      end
    end

    assign wayHit     = validArr[reqIdx][w] && (secMem[reqIdx] == reqSec) &&
                        (tagMem[reqIdx] == fetchPtag);
    assign hitVec[w]  = wayHit;
    assign wayBeat[w] = rdBeat;
  end

  always_comb begin
    hitData = '0;
    for (int w = 0; w < WAYS; w++)
      if (hitVec[w]) hitData = hitData | wayBeat[w];
  end

  assign hitAny       = strobes.lookup && (|hitVec);
  assign respData     = strobes.fwdSel ? memRespData : hitData;
  assign memReqAddr   = {reqPtag, reqIdx, reqBeat, 3'b000};
  assign memReqSecure = reqSec;

  AST_HIT_ONE_WAY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.lookup |-> $onehot0(hitVec)); // R4
  AST_REFILL_COUNT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strobes.lookup |=> firstBeat); // R7

endmodule

// File: rtl/icache_vipt.sv
module icache_vipt
  import icache_pkg::*;
#(
  parameter  int CACHE_KB = 16,
  parameter  int VA_W     = 32,
  parameter  int PA_W     = 32,
  localparam int SETS     = (CACHE_KB * 1024) / (LINE_BYTES * WAYS),
  localparam int IDX_W    = $clog2(SETS),
  localparam int PTAG_W   = PA_W - OFF_W - IDX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fetchValid,
  output logic               fetchReady,
  input  logic [VA_W-1:0]    fetchVaddr,
  input  logic               fetchSecure,
  input  logic [PTAG_W-1:0]  fetchPtag,
  output logic               respValid,
  output logic [DATA_W-1:0]  respData,
  input  logic               invReq,
  output logic               invBusy,
  output logic               memReqValid,
  input  logic               memReqReady,
  output logic [PA_W-1:0]    memReqAddr,
  output logic               memReqSecure,
  input  logic               memRespValid,
  input  logic [DATA_W-1:0]  memRespData
);

  initial begin : size_check
    AST_SIZE_LEGAL: assert (CACHE_KB == 16 || CACHE_KB == 32 || CACHE_KB == 64)
      else $error("cache size must be 16, 32 or 64 KB"); // R2
  end

  ctrlStrobes_t strobes;
  logic hitAny, firstBeat, lastBeat, invLast;

  icache_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .fetchValid   (fetchValid),
    .invReq       (invReq),
    .memReqReady  (memReqReady),
    .memRespValid (memRespValid),
    .hitAny       (hitAny),
    .firstBeat    (firstBeat),
    .lastBeat     (lastBeat),
    .invLast      (invLast),
    .strobes      (strobes),
    .fetchReady   (fetchReady),
    .respValid    (respValid),
    .invBusy      (invBusy),
    .memReqValid  (memReqValid)
  );

  icache_datapath #(
    .SETS   (SETS),
    .IDX_W  (IDX_W),
    .PTAG_W (PTAG_W),
    .VA_W   (VA_W),
    .PA_W   (PA_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .fetchVaddr   (fetchVaddr),
    .fetchSecure  (fetchSecure),
    .fetchPtag    (fetchPtag),
    .memRespData  (memRespData),
    .hitAny       (hitAny),
    .firstBeat    (firstBeat),
    .lastBeat     (lastBeat),
    .invLast      (invLast),
    .respData     (respData),
    .memReqAddr   (memReqAddr),
    .memReqSecure (memReqSecure)
  );

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memReqAddr) && $stable(memReqSecure)); // R6

endmodule

// File: tb/icache_vipt_tb_top.sv
module icache_vipt_tb_top;

  localparam int CACHE_KB = 16;
  localparam int SETS     = CACHE_KB * 1024 / 128;
  localparam int IDX_W    = $clog2(SETS);
  localparam int PTAG_W   = 32 - 5 - IDX_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fetchValid = 1'b0, fetchSecure = 1'b0, invReq = 1'b0;
  logic memReqReady = 1'b0, memRespValid = 1'b0;
  logic [31:0] fetchVaddr = '0;
  logic [PTAG_W-1:0] fetchPtag = '0;
  logic [63:0] memRespData = '0;
  logic fetchReady, respValid, invBusy, memReqValid, memReqSecure;
  logic [63:0] respData;
  logic [31:0] memReqAddr;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  icache_vipt #(.CACHE_KB(CACHE_KB)) dut_i (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchReady(fetchReady),
    .fetchVaddr(fetchVaddr), .fetchSecure(fetchSecure), .fetchPtag(fetchPtag),
    .respValid(respValid), .respData(respData), .invReq(invReq), .invBusy(invBusy),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memReqSecure(memReqSecure), .memRespValid(memRespValid), .memRespData(memRespData)
  );

  // reference model
  logic [PTAG_W-1:0] mTag [SETS][4];
  bit                mSec [SETS][4];
  bit                mVal [SETS][4];
  int                mRr  [SETS];

  function automatic logic [63:0] memWord(logic [PTAG_W-1:0] pt, logic [IDX_W-1:0] ix,
                                          logic [1:0] bt);
    logic [31:0] a = {pt, ix, bt, 3'b000};
    return {a ^ 32'hC3A5_0F1E, ~a + 32'd7};
  endfunction

  function automatic int modelWay(logic [IDX_W-1:0] ix, logic [PTAG_W-1:0] pt, bit sc);
    for (int w = 0; w < 4; w++)
      if (mVal[ix][w] && mTag[ix][w] == pt && mSec[ix][w] == sc) return w;
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // one fetch; req names the requirement the hit/miss outcome belongs to
  task automatic fetchOne(input logic [31:0] va, input logic [PTAG_W-1:0] pt,
                          input bit sc, input string req, output bit wasHit);
    logic [IDX_W-1:0] ix = va[IDX_W+4:5];
    logic [1:0] bt = va[4:3];
    int way = modelWay(ix, pt, sc);
    @(negedge clk);
    fetchValid = 1; fetchVaddr = va; fetchSecure = sc;
    while (!fetchReady) @(negedge clk);
    @(negedge clk);
    fetchValid = 0; fetchPtag = pt;
    #1;
    wasHit = (way >= 0);
    check(fetchReady == 0, "R10", "fetchReady during lookup", 64'(fetchReady), 0);
    if (way >= 0) begin
      check(respValid == 1, req, "hit respValid", 64'(respValid), 1);
      check(respData == memWord(pt, ix, bt), req, "hit data", respData, memWord(pt, ix, bt));
      return;
    end
    check(respValid == 0, req, "miss respValid", 64'(respValid), 0);
    @(negedge clk);
    check(memReqValid == 1, "R6", "memReqValid", 64'(memReqValid), 1);
    check(memReqAddr == {pt, ix, bt, 3'b000}, "R6", "memReqAddr", 64'(memReqAddr),
          64'({pt, ix, bt, 3'b000}));
    check(memReqSecure == sc, "R5", "memReqSecure", 64'(memReqSecure), 64'(sc));
    for (int g = $urandom_range(2, 0); g > 0; g--) begin
      @(negedge clk);
      check(memReqValid == 1 && memReqAddr == {pt, ix, bt, 3'b000}, "R6", "request held",
            64'(memReqAddr), 64'({pt, ix, bt, 3'b000}));
    end
    memReqReady = 1;
    @(negedge clk);
    memReqReady = 0;
    check(memReqValid == 0, "R10", "no second request", 64'(memReqValid), 0);
    for (int k = 0; k < 4; k++) begin
      logic [1:0] kb = bt + 2'(k);
      for (int g = $urandom_range(1, 0); g > 0; g--) @(negedge clk);
      memRespValid = 1; memRespData = memWord(pt, ix, kb);
      #1;
      if (k == 0) begin
        check(respValid == 1, "R7", "forward valid", 64'(respValid), 1);
        check(respData == memWord(pt, ix, kb), "R7", "forward data", respData, memWord(pt, ix, kb));
      end else begin
        check(respValid == 0, "R7", "later beat not returned", 64'(respValid), 0);
      end
      check(fetchReady == 0, "R10", "fetchReady during refill", 64'(fetchReady), 0);
      @(negedge clk);
      memRespValid = 0;
    end
    mTag[ix][mRr[ix]] = pt; mSec[ix][mRr[ix]] = sc; mVal[ix][mRr[ix]] = 1;
    mRr[ix] = (mRr[ix] + 1) % 4;
  endtask

  task automatic expectOutcome(input logic [31:0] va, input logic [PTAG_W-1:0] pt,
                               input bit sc, input bit expHit, input string req);
    bit h;
    fetchOne(va, pt, sc, req, h);
    check(h == expHit, req, "model hit/miss", 64'(h), 64'(expHit));
  endtask

  function automatic logic [31:0] mkVa(logic [19:0] hi, logic [IDX_W-1:0] ix, logic [1:0] bt);
    return 32'({hi, ix, bt, 3'b000});
  endfunction

  task automatic doInvalidate();
    int cnt = 0;
    @(negedge clk); invReq = 1;
    @(negedge clk); invReq = 0;
    while (invBusy) begin
      check(fetchReady == 0, "R9", "fetchReady while invalidating", 64'(fetchReady), 0);
      cnt++;
      @(negedge clk);
    end
    check(cnt == SETS + 1, "R9", "invBusy cycles", 64'(cnt), 64'(SETS + 1));
    for (int s = 0; s < SETS; s++) for (int w = 0; w < 4; w++) mVal[s][w] = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [PTAG_W-1:0] ptPool [6];
    logic [IDX_W-1:0]  ixPool [4];
    void'($urandom(32'd20240611));
    for (int s = 0; s < SETS; s++) begin
      mRr[s] = 0;
      for (int w = 0; w < 4; w++) begin mVal[s][w] = 0; mSec[s][w] = 0; mTag[s][w] = '0; end
    end
    ptPool = '{20'h00010, 20'h00011, 20'hABCDE, 20'h7FFFF, 20'h00000, 20'h12345};
    ixPool = '{7'd0, 7'd3, 7'd77, 7'(SETS - 1)};

    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(fetchReady == 1, "R1", "fetchReady after reset", 64'(fetchReady), 1);
    check(respValid == 0, "R1", "respValid after reset", 64'(respValid), 0);
    check(memReqValid == 0, "R1", "memReqValid after reset", 64'(memReqValid), 0);
    check(invBusy == 0, "R1", "invBusy after reset", 64'(invBusy), 0);

    // R1 first fetch misses, R3 repeat hits; R7 middle beat wraps, other beats stored
    expectOutcome(mkVa(20'h1, 7'd5, 2'd2), 20'h00ABC, 0, 0, "R1");
    expectOutcome(mkVa(20'h1, 7'd5, 2'd2), 20'h00ABC, 0, 1, "R3");
    expectOutcome(mkVa(20'h1, 7'd5, 2'd0), 20'h00ABC, 0, 1, "R7");
    expectOutcome(mkVa(20'h1, 7'd5, 2'd1), 20'h00ABC, 0, 1, "R7");
    // R4 virtual upper bits ignored, other physical tag misses
    expectOutcome(mkVa(20'hF0F0F, 7'd5, 2'd3), 20'h00ABC, 0, 1, "R4");
    expectOutcome(mkVa(20'h1, 7'd5, 2'd3), 20'h00ABD, 0, 0, "R4");
    // R5 other world misses, then both worlds hit
    expectOutcome(mkVa(20'h1, 7'd5, 2'd2), 20'h00ABC, 1, 0, "R5");
    expectOutcome(mkVa(20'h1, 7'd5, 2'd2), 20'h00ABC, 1, 1, "R5");
    expectOutcome(mkVa(20'h1, 7'd5, 2'd2), 20'h00ABC, 0, 1, "R5");

    // R9 invalidate, then stale line misses
    doInvalidate();
    expectOutcome(mkVa(20'h1, 7'd5, 2'd2), 20'h00ABC, 0, 0, "R9");

    // R8 round robin in set 9: five tags, first evicted
    for (int t = 0; t < 5; t++)
      expectOutcome(mkVa(20'h2, 7'd9, 2'(t)), PTAG_W'(20'h300 + t), 0, 0, "R8");
    expectOutcome(mkVa(20'h2, 7'd9, 2'd1), 20'h301, 0, 1, "R8");
    expectOutcome(mkVa(20'h2, 7'd9, 2'd0), 20'h304, 0, 1, "R8");
    expectOutcome(mkVa(20'h2, 7'd9, 2'd0), 20'h300, 0, 0, "R8");
    expectOutcome(mkVa(20'h2, 7'd9, 2'd1), 20'h301, 0, 0, "R8");

    // random traffic over a small pool of sets and tags
    for (int i = 0; i < 400; i++) begin
      bit h;
      logic [31:0] va = $urandom;
      va[IDX_W+4:5] = ixPool[$urandom_range(3, 0)];
      fetchOne(va, ptPool[$urandom_range(5, 0)], 1'($urandom_range(1, 0)), "R3", h);
      if (i == 200) doInvalidate();
    end

    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule